// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address that a synchronous burst memory uses on every clock. A burst begins when either of two address strobes is high at a rising clock edge. The external address is then captured, and from the next cycle onward the sequencer steps through the four words of an aligned group. Only the two lowest address bits change during a burst, and the upper bits stay fixed.

Each step is taken only on a cycle with the advance input high. A mode input chooses between two step orders. In linear order the low bits count upward and wrap modulo 4. In interleaved order the low bits are the start bits XORed with a beat count. The mode is captured along with the address, so one burst always uses one order. A new strobe is accepted on any cycle, including back-to-back cycles and the middle of a running burst, with no penalty. The block also raises a flag while the fourth beat of the burst is being presented.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low and after it is released, `addr_out` is 0 and `last_beat` is 0 until the first strobe.
- R2: When `strobe_a` is high at a rising edge, `addr_out` equals the `addr_in` sampled at that edge from just after that edge, and `last_beat` is 0.
- R3: When `strobe_b` is high at a rising edge, it loads `addr_in` with exactly the same effect as `strobe_a`.
- R4: A strobe on every consecutive cycle loads a fresh address on each of those cycles.
- R5: With `ilv_mode` = 0 captured at the strobe, after k advances (k = 0..3) the low 2 bits of `addr_out` are (start + k) mod 4. Example: start 2 gives 2,3,0,1.
- R6: With `ilv_mode` = 1 captured at the strobe, after k advances the low 2 bits of `addr_out` are start XOR k. Example: start 1 gives 1,0,3,2.
- R7: At an edge with no strobe and `adv` low, `addr_out` and `last_beat` keep their values.
- R8: Bits above bit 1 of `addr_out` stay unchanged at every edge without a strobe.
- R9: A strobe during a burst loads the new address and resets the beat count to 0, even if `adv` is high in that cycle.
- R10: `last_beat` is 1 exactly when three advances have occurred since the last strobe (the fourth beat). A further advance wraps the sequence to the start address and clears `last_beat`.
- R11: A change of `ilv_mode` between strobes has no effect on the order of the running burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_in | input | ADDR_W | External start address |
| strobe_a | input | 1 | First burst-start strobe |
| strobe_b | input | 1 | Second burst-start strobe |
| adv | input | 1 | Advance to the next beat |
| ilv_mode | input | 1 | Order select: 0 linear, 1 interleaved |
| addr_out | output | ADDR_W | Current word address |
| last_beat | output | 1 | High on the fourth beat of a burst |

## Verification
Bursts are started at every low-bit start value in both orders. Start value 0 gives the same sequence in both orders. Start values 1 and 3 give different sequences, so those cases show whether the mode selects the right arithmetic. Advance is held low on some cycles in the middle of a burst, which shows whether stepping is really gated. Strobes are applied on consecutive cycles, in the middle of a burst together with advance, and with the mode toggled between them. These patterns separate a load that resets the count from one that keeps it, and a mode captured at the strobe from a mode read live.

// File: rtl/bas_pkg.sv
package bas_pkg;
    localparam int BEAT_BITS = 2;
    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_XOR    = 1'b1
    } order_e;
endpackage

// File: rtl/bas_order.sv
// Maps a start value and a beat count to the low address bits.
module bas_order #(
    parameter int W = bas_pkg::BEAT_BITS
) (
    input  logic [W-1:0]     start,
    input  logic [W-1:0]     count,
    input  bas_pkg::order_e  order,
    output logic [W-1:0]     beat
);
    logic [W-1:0] lin_w;
    logic [W-1:0] xor_w;

    always_comb begin
        lin_w = start + count;   // wraps modulo 2**W
        xor_w = start ^ count;
        beat  = (order == bas_pkg::ORD_XOR) ? xor_w : lin_w;
    end
endmodule

// File: rtl/bas_last.sv
// Flags the final beat of a burst (count saturated at all ones).
module bas_last #(
    parameter int W = bas_pkg::BEAT_BITS
) (
    input  logic [W-1:0] count,
    output logic         is_last
);
    always_comb is_last = &count;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              strobe_a,
    input  logic              strobe_b,
    input  logic              adv,
    input  logic              ilv_mode,
    output logic [ADDR_W-1:0] addr_out,
    output logic              last_beat
);
    import bas_pkg::*;

    localparam int BB = BEAT_BITS;
    localparam int UW = ADDR_W - BB;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [BB-1:0]     cnt;
        order_e            order;
    } seq_t;

    seq_t st_d, st_q;
    logic load_w;
    logic [BB-1:0] low_w;

    always_comb begin
        load_w = strobe_a | strobe_b;
        st_d   = st_q;
        if (load_w) begin
            st_d.base  = addr_in;
            st_d.cnt   = '0;
            st_d.order = order_e'(ilv_mode);
        end else if (adv) begin
            st_d.cnt   = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{base: '0, cnt: '0, order: ORD_LINEAR};
        end else begin
            st_q <= st_d;
        end
    end

    bas_order #(.W(BB)) u_order (
        .start (st_q.base[BB-1:0]),
        .count (st_q.cnt),
        .order (st_q.order),
        .beat  (low_w)
    );

    bas_last #(.W(BB)) u_last (
        .count   (st_q.cnt),
        .is_last (last_beat)
    );

    assign addr_out = {st_q.base[ADDR_W-1:BB], low_w};

    logic [UW-1:0] unused_upper_w;
    assign unused_upper_w = '0;
endmodule

// File: rtl/bas_checker.sv
module bas_checker #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_in,
    input logic              strobe_a,
    input logic              strobe_b,
    input logic              adv,
    input logic [ADDR_W-1:0] addr_out,
    input logic              last_beat
);
    logic any_stb;
    assign any_stb = strobe_a | strobe_b;

    AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        any_stb |=> (addr_out == $past(addr_in)) && !last_beat); // R2

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_stb && !adv) |=> $stable(addr_out) && $stable(last_beat)); // R7

    AST_UPPER_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !any_stb |=> $stable(addr_out[ADDR_W-1:2])); // R8

    AST_WRAP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_stb && adv && last_beat) |=> !last_beat); // R10

    AST_RESTART_MID: assert property (@(posedge clk) disable iff (!rst_n)
        (any_stb && adv) |=> !last_beat && (addr_out == $past(addr_in))); // R9
endmodule

bind burst_addr_seq bas_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_in   (addr_in),
    .strobe_a  (strobe_a),
    .strobe_b  (strobe_b),
    .adv       (adv),
    .addr_out  (addr_out),
    .last_beat (last_beat)
);

// File: tb/sim_burst_addr_seq.sv
`timescale 1ns/1ps
module sim_burst_addr_seq;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic          strobe_a = 1'b0;
    logic          strobe_b = 1'b0;
    logic          adv = 1'b0;
    logic          ilv_mode = 1'b0;
    logic [AW-1:0] addr_out;
    logic          last_beat;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
        .strobe_a(strobe_a), .strobe_b(strobe_b), .adv(adv),
        .ilv_mode(ilv_mode), .addr_out(addr_out), .last_beat(last_beat)
    );

    function automatic logic [AW-1:0] expect_addr(logic [AW-1:0] st, int k, logic ilv);
        logic [1:0] lo;
        lo = ilv ? (st[1:0] ^ 2'(k)) : 2'(st[1:0] + 2'(k));
        return {st[AW-1:2], lo};
    endfunction

    task automatic chk(string req, logic [AW-1:0] act, logic [AW-1:0] exp,
                       logic lact, logic lexp);
        total++;
        if (act !== exp || lact !== lexp) begin
            bad++;
            $display("FAIL %s: addr=%h last=%b expected addr=%h last=%b",
                     req, act, lact, exp, lexp);
        end
    endtask

    // drive inputs, one rising edge, then sample 1 ns later
    task automatic step(logic sa, logic sb, logic a, logic m, logic [AW-1:0] ad);
        strobe_a = sa; strobe_b = sb; adv = a; ilv_mode = m; addr_in = ad;
        @(posedge clk);
        #1;
        strobe_a = 1'b0; strobe_b = 1'b0; adv = 1'b0;
    endtask

    task automatic run_burst(string req, logic use_b, logic ilv, logic [AW-1:0] st);
        step(!use_b, use_b, 1'b0, ilv, st);
        chk(req, addr_out, expect_addr(st, 0, ilv), last_beat, 1'b0);
        for (int k = 1; k < 4; k++) begin
            step(1'b0, 1'b0, 1'b1, ilv, '0);
            chk(req, addr_out, expect_addr(st, k, ilv), last_beat, k == 3);
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk("R1 in reset", addr_out, '0, last_beat, 1'b0);
        rst_n = 1'b1;
        step(1'b0, 1'b0, 1'b0, 1'b0, 20'hABCDE);
        chk("R1 after release", addr_out, '0, last_beat, 1'b0);
    endtask

    task automatic t_loads;
        step(1'b1, 1'b0, 1'b0, 1'b0, 20'h12345);
        chk("R2 strobe_a load", addr_out, 20'h12345, last_beat, 1'b0);
        step(1'b0, 1'b1, 1'b0, 1'b0, 20'h54321);
        chk("R3 strobe_b load", addr_out, 20'h54321, last_beat, 1'b0);
    endtask

    task automatic t_back_to_back;
        for (int i = 0; i < 4; i++) begin
            logic [AW-1:0] a;
            a = 20'h0F000 + 20'(i * 7);
            step(i[0], !i[0], 1'b1, 1'b0, a);
            chk("R4 back-to-back", addr_out, a, last_beat, 1'b0);
        end
    endtask

    task automatic t_orders;
        for (int s = 0; s < 4; s++) begin
            run_burst("R5 linear", s[0], 1'b0, 20'hA5A50 | 20'(s));
            run_burst("R6 interleaved", !s[0], 1'b1, 20'h3C3C0 | 20'(s));
        end
    endtask

    task automatic t_hold_and_wrap;
        logic [AW-1:0] st;
        st = 20'h77771;
        step(1'b1, 1'b0, 1'b0, 1'b0, st);
        step(1'b0, 1'b0, 1'b1, 1'b0, '0);
        step(1'b0, 1'b0, 1'b0, 1'b0, 20'hFFFFF);
        chk("R7 hold no adv", addr_out, expect_addr(st, 1, 1'b0), last_beat, 1'b0);
        step(1'b0, 1'b0, 1'b0, 1'b1, 20'h00000);
        chk("R8 upper frozen", addr_out, expect_addr(st, 1, 1'b0), last_beat, 1'b0);
        step(1'b0, 1'b0, 1'b1, 1'b0, '0);
        step(1'b0, 1'b0, 1'b1, 1'b0, '0);
        chk("R10 last beat", addr_out, expect_addr(st, 3, 1'b0), last_beat, 1'b1);
        step(1'b0, 1'b0, 1'b0, 1'b0, '0);
        chk("R7 hold on last", addr_out, expect_addr(st, 3, 1'b0), last_beat, 1'b1);
        step(1'b0, 1'b0, 1'b1, 1'b0, '0);
        chk("R10 wrap", addr_out, st, last_beat, 1'b0);
    endtask

    task automatic t_restart;
        step(1'b0, 1'b1, 1'b0, 1'b1, 20'h11112);
        step(1'b0, 1'b0, 1'b1, 1'b1, '0);
        step(1'b0, 1'b0, 1'b1, 1'b1, '0);
        step(1'b1, 1'b0, 1'b1, 1'b0, 20'h22223);
        chk("R9 restart mid-burst", addr_out, 20'h22223, last_beat, 1'b0);
        step(1'b0, 1'b0, 1'b1, 1'b0, '0);
        chk("R9 count reset", addr_out, expect_addr(20'h22223, 1, 1'b0), last_beat, 1'b0);
    endtask

    task automatic t_mode_change;
        logic [AW-1:0] st;
        st = 20'h40001;
        step(1'b1, 1'b0, 1'b0, 1'b1, st);
        for (int k = 1; k < 4; k++) begin
            step(1'b0, 1'b0, 1'b1, k[0], '0);
            chk("R11 mode ignored mid-burst", addr_out, expect_addr(st, k, 1'b1),
                last_beat, k == 3);
        end
    endtask

    initial begin
        t_reset();
        t_loads();
        t_back_to_back();
        t_orders();
        t_hold_and_wrap();
        t_restart();
        t_mode_change();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: addr=%h last=%b expected run to end", addr_out, last_beat);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule